// File: doc/BRIEF.md
# Video Codec Mode Control Register

This block is the host-visible mode register of a video compression engine. A single 16-bit word holds the video interface configuration and a software reset bit. The configuration fields come out as separate signals. The software reset bit decides whether the processing core may run. The host reaches the register through a plain synchronous port: one strobe with data for writes, and one strobe for reads that returns the stored word on the following cycle.

The core returns two indications to the block. The first is a one-cycle strobe at the end of each field. The second is a busy level. When software reset is set in encode mode, the core finishes the field it is working on before it is suspended. In decode mode the core is suspended at once. Configuration fields may change only while software reset is set, or in the same write that sets it. A write that tries to change them while software reset stays clear leaves them as they were and raises a sticky error output. The host interrupt pin reflects an internal request and has a programmable active level.

Top module: `vmode_reg`

## Requirements
- R1: After hardware reset the register reads 0x0980: slave, 525 lines, encode, square pixel on, bipolar colour, host bin width, software reset set, HSYNC high in blanking, interrupt pin active low. In this state run_en is 0 and mode_err is 0.
- R2: The field outputs follow these bit positions: bit 5 master (1) or slave (0), bit 6 625 lines (1), bit 7 encode (1) or decode (0), bit 8 square pixel on (1), bit 9 unipolar (1), bit 10 external bin width (1), bit 11 software reset, bit 12 HSYNC low in blanking (1), bit 13 interrupt pin active high (1).
- R3: Bits 15:14 and 4:0 always read as zero, whatever value was written to them.
- R4: The word is sampled into rd_data on the clock edge where rd_en is high. rd_data then holds that value until the next read.
- R5: While software reset is set and run_en is low, run_en stays low.
- R6: In decode mode, a write that sets software reset drops run_en at the clock edge of that write.
- R7: In encode mode with software reset set, run_en drops at the edge where field_end is high. If core_busy is low, run_en drops at once.
- R8: run_en rises on the cycle after the edge that clears software reset. If the suspension had not yet taken effect, run_en stays high with no gap.
- R9: A write with bit 11 clear, made while software reset is clear, leaves bits 5–10 and 12–13 unchanged. If that write differs from the stored bits in any of those positions, mode_err becomes 1.
- R10: Configuration bits are taken from a write when software reset is already set, or when the write itself sets bit 11.
- R11: hirq_pin equals irq_req when bit 13 is 1, and equals its inverse when bit 13 is 0.
- R12: Once set, mode_err stays at 1 until hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| field_end | input | 1 | One-cycle end-of-field strobe from the core |
| core_busy | input | 1 | Core is inside a field |
| irq_req | input | 1 | Internal interrupt request, active high |
| is_master | output | 1 | Master timing mode |
| is_625 | output | 1 | 625-line mode |
| is_encode | output | 1 | Encode mode |
| sq_pixel | output | 1 | Square pixel enabled |
| unipolar | output | 1 | Unipolar colour components |
| ext_binwidth | output | 1 | External processor computes bin widths |
| sw_reset | output | 1 | Software reset bit |
| hsync_low_blank | output | 1 | HSYNC low during blanking |
| hirq_act_high | output | 1 | Interrupt pin active high |
| run_en | output | 1 | Core may process |
| mode_err | output | 1 | Sticky blocked-write flag |
| hirq_pin | output | 1 | Host interrupt pin |

## Verification
The assertions assume that field_end and core_busy are driven synchronously and that field_end only pulses. They also assume that the host never expects a read and a write in the same cycle to return the new word. The bench drives every input on the falling edge and never issues a read in the same cycle as a write. It keeps core_busy steady across each suspension sequence, so that the encode and decode suspend paths can be told apart by the cycle in which run_en falls.

// File: rtl/vmode_reg.sv
module vmode_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          field_end,
  input  logic          core_busy,
  input  logic          irq_req,
  output logic          is_master,
  output logic          is_625,
  output logic          is_encode,
  output logic          sq_pixel,
  output logic          unipolar,
  output logic          ext_binwidth,
  output logic          sw_reset,
  output logic          hsync_low_blank,
  output logic          hirq_act_high,
  output logic          run_en,
  output logic          mode_err,
  output logic          hirq_pin
);
  localparam int B_MS   = 5;
  localparam int B_LINE = 6;
  localparam int B_ENC  = 7;
  localparam int B_SQ   = 8;
  localparam int B_UNI  = 9;
  localparam int B_DSP  = 10;
  localparam int B_SWR  = 11;
  localparam int B_HS   = 12;
  localparam int B_IRQ  = 13;
  localparam logic [DW-1:0] LIVE_MASK = DW'(((1 << (B_IRQ + 1)) - 1) & ~((1 << B_MS) - 1));
  localparam logic [DW-1:0] CFG_MASK  = LIVE_MASK & ~(DW'(1) << B_SWR);
  localparam logic [DW-1:0] RST_WORD  = (DW'(1) << B_ENC) | (DW'(1) << B_SQ) | (DW'(1) << B_SWR);

  logic [DW-1:0] mode_q, mode_d;
  logic          legal, blocked, stop;

  assign legal   = mode_q[B_SWR] | wr_data[B_SWR];
  assign blocked = wr_en & ~legal & (((wr_data ^ mode_q) & CFG_MASK) != '0);
  assign stop    = ~mode_q[B_ENC] | field_end | ~core_busy;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d[B_SWR] = wr_data[B_SWR];
      if (legal) mode_d = (mode_d & ~CFG_MASK) | (wr_data & CFG_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RST_WORD;
      mode_err <= 1'b0;
      run_en   <= 1'b0;
      rd_data  <= '0;
    end else begin
      mode_q   <= mode_d & LIVE_MASK;
      mode_err <= mode_err | blocked;
      if (mode_d[B_SWR]) run_en <= run_en & ~stop;
      else               run_en <= run_en | ~mode_q[B_SWR];
      if (rd_en) rd_data <= mode_q;
    end
  end

  assign is_master       = mode_q[B_MS];
  assign is_625          = mode_q[B_LINE];
  assign is_encode       = mode_q[B_ENC];
  assign sq_pixel        = mode_q[B_SQ];
  assign unipolar        = mode_q[B_UNI];
  assign ext_binwidth    = mode_q[B_DSP];
  assign sw_reset        = mode_q[B_SWR];
  assign hsync_low_blank = mode_q[B_HS];
  assign hirq_act_high   = mode_q[B_IRQ];
  assign hirq_pin        = ~(irq_req ^ mode_q[B_IRQ]);
endmodule

// File: rtl/vmode_reg_chk.sv
module vmode_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        field_end,
  input logic        is_master,
  input logic        is_625,
  input logic        is_encode,
  input logic        sq_pixel,
  input logic        unipolar,
  input logic        ext_binwidth,
  input logic        sw_reset,
  input logic        hsync_low_blank,
  input logic        hirq_act_high,
  input logic        run_en,
  input logic        mode_err
);
  logic [7:0] cfg;
  assign cfg = {is_master, is_625, is_encode, sq_pixel, unipolar, ext_binwidth,
                hsync_low_blank, hirq_act_high};

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:14] == 2'b00 && rd_data[4:0] == 5'b0);

  a_r5_stay_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset && !run_en |=> !run_en);

  a_r6_decode_now: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[11] && !is_encode |=> !run_en);

  a_r7_field_end_stop: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && sw_reset && field_end && !wr_en |=> !run_en);

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_reset) && !wr_en |=> run_en);

  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sw_reset && !wr_data[11] |=> $stable(cfg));

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);
endmodule

bind vmode_reg vmode_reg_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .field_end(field_end), .is_master(is_master), .is_625(is_625), .is_encode(is_encode),
  .sq_pixel(sq_pixel), .unipolar(unipolar), .ext_binwidth(ext_binwidth),
  .sw_reset(sw_reset), .hsync_low_blank(hsync_low_blank), .hirq_act_high(hirq_act_high),
  .run_en(run_en), .mode_err(mode_err)
);

// File: tb/vmode_reg_test.sv
module vmode_reg_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0, field_end = 0, core_busy = 0, irq_req = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic is_master, is_625, is_encode, sq_pixel, unipolar, ext_binwidth, sw_reset;
  logic hsync_low_blank, hirq_act_high, run_en, mode_err, hirq_pin;

  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  vmode_reg uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_expect(input logic [15:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 run_en", 16'(run_en), 16'd0);
    check("R1 err", 16'(mode_err), 16'd0);
    check("R1 fields", 16'({is_master, is_625, is_encode, sq_pixel, unipolar, ext_binwidth,
           sw_reset, hsync_low_blank, hirq_act_high}), 16'b0_0_1_1_0_0_1_0_0);
    check("R11 active low idle", 16'(hirq_pin), 16'd1);
    read_expect(16'h0980, "R1 readback");

    // R3 R10 R2: all bits written while suspended
    write(16'hFFFF);
    read_expect(16'h3FE0, "R3 R10 reserved zero");
    check("R2 fields", 16'({is_master, is_625, is_encode, sq_pixel, unipolar, ext_binwidth,
           sw_reset, hsync_low_blank, hirq_act_high}), 16'h1FF);
    check("R11 pol high idle", 16'(hirq_pin), 16'd0);
    irq_req = 1; #1;
    check("R11 pol high req", 16'(hirq_pin), 16'd1);
    irq_req = 0;

    // decode, then release
    write(16'h3F60);
    check("R2 decode bit7", 16'(is_encode), 16'd0);
    check("R5 held", 16'(run_en), 16'd0);
    write(16'h3760);
    check("R8 not yet", 16'(run_en), 16'd0);
    @(negedge clk);
    check("R8 resumed", 16'(run_en), 16'd1);

    // R9 blocked change
    write(16'h3740);
    check("R9 master kept", 16'(is_master), 16'd1);
    check("R9 err", 16'(mode_err), 16'd1);
    read_expect(16'h3760, "R9 readback");
    check("R9 still running", 16'(run_en), 16'd1);

    // R6 decode immediate
    core_busy = 1;
    write(16'h3F60);
    check("R6 stopped", 16'(run_en), 16'd0);
    check("R12 err kept", 16'(mode_err), 16'd1);

    // encode mode: wait for field end
    write(16'h3FE0);
    write(16'h37E0);
    @(negedge clk);
    check("R8 run encode", 16'(run_en), 16'd1);
    write(16'h3FE0);
    repeat (3) @(negedge clk);
    check("R7 waits field", 16'(run_en), 16'd1);
    field_end = 1;
    @(negedge clk);
    field_end = 0;
    check("R7 field stop", 16'(run_en), 16'd0);

    // R8 clear before field end: no gap
    write(16'h37E0);
    @(negedge clk);
    write(16'h3FE0);
    write(16'h37E0);
    check("R8 no gap a", 16'(run_en), 16'd1);
    @(negedge clk);
    check("R8 no gap b", 16'(run_en), 16'd1);

    // R7 idle core stops at once
    core_busy = 0;
    write(16'h3FE0);
    check("R7 idle stop", 16'(run_en), 16'd0);

    // R10 change in same write that sets swr
    write(16'h37E0);
    @(negedge clk);
    write(16'h3FC0);
    check("R10 master cleared", 16'(is_master), 16'd0);
    read_expect(16'h3FC0, "R10 readback");

    // R4 rd_data holds without rd_en
    write(16'h3FE0);
    @(negedge clk);
    check("R4 hold", rd_data, 16'h3FC0);

    // R12 cleared only by reset
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 err reset", 16'(mode_err), 16'd0);
    read_expect(16'h0980, "R1 after reset");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule